// File: doc/BRIEF.md
# Indexed-Access UART Clock Prescaler

This block sits beside a 16550-style byte register bus. It divides the UART reference clock by a fractional ratio before the clock reaches the baud divisor. The ratio is an 8-bit value in units of one eighth. For example, 0x09 divides by 1.125.

Software can only reach the ratio through a gated path:

1. Write the page key 0xBF to the line-control register. This maps the enhanced-feature register onto address 2.
2. Set the enhanced-mode bit in the enhanced-feature register.
3. Restore the line-control register.
4. Write the target index to the scratch/index address (7).
5. Write the data byte to the indexed-data address (5).

The division takes effect only while the clock-select bit of the modem-control register is set. While that bit is clear, the reference clock passes straight through, and the strobe is high on every cycle.

The output is a one-cycle clock-enable strobe at the prescaled average rate. A phase accumulator adds 8 on every reference clock. When the sum reaches the ratio, the accumulator subtracts the ratio and issues a pulse. The pulse rate is therefore exactly 8/ratio, with no long-term drift. The block also drives the current ratio on a readback port.

Top module: `uart_prescale_top`

## Requirements
- R1: After reset, the line-control and modem-control registers read 0x00 at addresses 3 and 4, and the index register reads 0x00 at address 7. The ratio readback is 0x08, and the strobe is high on every cycle.
- R2: The enhanced-feature register appears at address 2 only while the line-control register holds 0xBF. Paged in, it takes writes and reads them back. Paged out, address 2 reads 0x00 and writes there leave the register unchanged. The enhanced-mode bit (bit 4) keeps its value after paging out.
- R3: When enhanced mode is on and the index register holds 0x01, a write to address 5 loads the data byte into the ratio. The new ratio shows on the readback port one cycle later.
- R4: A write to address 5 while enhanced-mode bit 4 is clear leaves the ratio unchanged.
- R5: A write to address 5 while the index register holds any value other than 0x01 leaves the ratio unchanged. The index register reads back at address 7.
- R6: While modem-control bit 7 (clock select) is clear, the strobe is high on every cycle, whatever the ratio.
- R7: While clock select is set and the ratio P is 8 or more, the strobe follows a fixed pattern. Count cycles k = 0, 1, 2, … from the edge that loads the ratio or sets clock select. The strobe is high in cycle k exactly when floor(8(k+1)/P) > floor(8k/P). This gives exactly 8 pulses in every P cycles.
- R8: A ratio below 8, including 0, divides by 1. With clock select set, the strobe is then high on every cycle.
- R9: The line-control and modem-control registers read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| prescale_value | output | 8 | Current prescaler ratio in eighths |
| clk_sel | output | 1 | Modem-control clock-select bit |
| baud_clk_en | output | 1 | Clock-enable strobe at the prescaled rate |

## Verification
Each block of state shows its errors at the ports within a few cycles:

- **Wrong paging or enhanced-mode latch.** The error appears on the next read of address 2, or on the readback port one cycle after an indexed write that should have been dropped or taken.
- **Accumulator error.** A stale value after a ratio load, a wrong subtract, or a missed wrap changes the strobe pattern within the first P cycles after the load. The bench therefore compares the strobe cycle by cycle against the closed-form floor pattern, rather than only counting pulses.
- **Bad clock-select path.** This breaks the every-cycle strobe on the first cycle after the bit changes.

// File: rtl/uart_prescale_pkg.sv
package uart_prescale_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FRAC_W   = 3;
  localparam int unsigned STEP     = 1 << FRAC_W;

  localparam logic [ADDR_W-1:0] A_EFR_PAGED = 3'd2;
  localparam logic [ADDR_W-1:0] A_LCR       = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCR       = 3'd4;
  localparam logic [ADDR_W-1:0] A_IDX_DATA  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IDX_SEL   = 3'd7;

  localparam logic [DATA_W-1:0] PAGE_KEY      = 8'hBF;
  localparam int unsigned       ENH_BIT       = 4;
  localparam int unsigned       CLKSEL_BIT    = 7;
  localparam logic [DATA_W-1:0] IDX_PRESCALE  = 8'h01;
  localparam logic [DATA_W-1:0] PRESCALE_INIT = 8'(STEP);

  typedef struct packed {
    logic [DATA_W-1:0] lcr;
    logic [DATA_W-1:0] mcr;
    logic [DATA_W-1:0] efr;
    logic [DATA_W-1:0] idx;
  } host_regs_t;
endpackage

// File: rtl/uart_prescale_regs.sv
module uart_prescale_regs
  import uart_prescale_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              enh_mode,
  output logic              sel,
  output logic [DATA_W-1:0] idx_value,
  output logic              data_wr
);
  host_regs_t regs_q, regs_d;
  logic       paged;

  assign paged = (regs_q.lcr == PAGE_KEY);

  always_comb begin
    regs_d = regs_q;
    if (wr) begin
      unique case (addr)
        A_LCR:       regs_d.lcr = wdata;
        A_MCR:       regs_d.mcr = wdata;
        A_IDX_SEL:   regs_d.idx = wdata;
        A_EFR_PAGED: if (paged) regs_d.efr = wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_LCR:       rdata = regs_q.lcr;
      A_MCR:       rdata = regs_q.mcr;
      A_IDX_SEL:   rdata = regs_q.idx;
      A_EFR_PAGED: rdata = paged ? regs_q.efr : '0;
      default:     rdata = '0;
    endcase
  end

  assign enh_mode  = regs_q.efr[ENH_BIT];
  assign sel       = regs_q.mcr[CLKSEL_BIT];
  assign idx_value = regs_q.idx;
  assign data_wr   = wr && (addr == A_IDX_DATA);

  p_efr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_EFR_PAGED && !paged) |=> $stable(enh_mode));
endmodule

// File: rtl/uart_prescale_window.sv
module uart_prescale_window
  import uart_prescale_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_mode,
  input  logic [DATA_W-1:0] idx_value,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ratio,
  output logic              reload
);
  logic [DATA_W-1:0] ratio_q, ratio_d;

  assign reload = data_wr && enh_mode && (idx_value == IDX_PRESCALE);

  always_comb begin
    ratio_d = ratio_q;
    if (reload) ratio_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ratio_q <= PRESCALE_INIT;
    else        ratio_q <= ratio_d;
  end

  assign ratio = ratio_q;

  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !enh_mode) |=> $stable(ratio));
  p_other_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx_value != IDX_PRESCALE) |=> $stable(ratio));
endmodule

// File: rtl/uart_prescale_accum.sv
module uart_prescale_accum
  import uart_prescale_pkg::*;
#(
  parameter int unsigned RATIO_W = DATA_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               reload,
  input  logic [RATIO_W-1:0] ratio,
  output logic               clk_en
);
  localparam int unsigned ACC_W = RATIO_W + 1;
  localparam logic [ACC_W-1:0] STEP_A = ACC_W'(STEP);

  logic [ACC_W-1:0] acc_q, acc_d, sum, p_eff;
  logic             wrap;

  assign p_eff = (ACC_W'(ratio) < STEP_A) ? STEP_A : ACC_W'(ratio);
  assign sum   = acc_q + STEP_A;
  assign wrap  = (sum >= p_eff);

  always_comb begin
    acc_d = acc_q;
    if (!sel || reload) acc_d = '0;
    else if (wrap)      acc_d = sum - p_eff;
    else                acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign clk_en = !sel || wrap;

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> clk_en);
  p_acc_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < p_eff || $past(reload) || $changed(ratio));
  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && p_eff >= 2*STEP_A && clk_en && !reload) |=>
      (!sel || p_eff < 2*STEP_A || !clk_en));
endmodule

// File: rtl/uart_prescale_top.sv
module uart_prescale_top
  import uart_prescale_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] prescale_value,
  output logic              clk_sel,
  output logic              baud_clk_en
);
  logic              rst_meta, rst_sync_n;
  logic              enh_mode, sel, data_wr, reload;
  logic [DATA_W-1:0] idx_value, ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  uart_prescale_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rdata(bus_rdata), .enh_mode(enh_mode), .sel(sel),
    .idx_value(idx_value), .data_wr(data_wr)
  );

  uart_prescale_window u_window (
    .clk(clk), .rst_n(rst_sync_n), .enh_mode(enh_mode), .idx_value(idx_value),
    .data_wr(data_wr), .wdata(bus_wdata), .ratio(ratio), .reload(reload)
  );

  uart_prescale_accum #(.RATIO_W(DATA_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel), .reload(reload),
    .ratio(ratio), .clk_en(baud_clk_en)
  );

  assign prescale_value = ratio;
  assign clk_sel        = sel;

  p_reset_ratio_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (prescale_value == PRESCALE_INIT));
endmodule

// File: tb/uart_prescale_top_tb.sv
module uart_prescale_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] prescale_value;
  logic       clk_sel;
  logic       baud_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_ratio;

  always #2 clk = ~clk;

  uart_prescale_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prescale_value(prescale_value), .clk_sel(clk_sel),
    .baud_clk_en(baud_clk_en)
  );

  function automatic bit exp_pulse(int p, int k);
    int pe;
    pe = (p < 8) ? 8 : p;
    return ((8 * (k + 1)) / pe) != ((8 * k) / pe);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_enh(bit on);
    bus_write(3'd3, 8'hBF);
    bus_write(3'd2, on ? 8'h10 : 8'h00);
    bus_write(3'd3, 8'h03);
  endtask

  // Starts right after the loading edge; k = 0 is the current negedge
  task automatic check_pattern(string req, int p, int cycles);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      if (baud_clk_en !== exp_pulse(p, k)) begin
        if (bad == 0)
          $display("FAIL %s: strobe cycle %0d ratio %0d actual %0b expected %0b",
                   req, k, p, baud_clk_en, exp_pulse(p, k));
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    bus_addr = 3'd0; bus_wdata = 8'h00; bus_wr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(3'd3, rd); check("R1 lcr", rd, 0);
    bus_read(3'd4, rd); check("R1 mcr", rd, 0);
    bus_read(3'd7, rd); check("R1 idx", rd, 0);
    check("R1 ratio", prescale_value, 8'h08);
    check("R1 strobe", baud_clk_en, 1);
    exp_ratio = 8'h08;

    // R9 readback
    bus_write(3'd3, 8'h5A); bus_read(3'd3, rd); check("R9 lcr", rd, 8'h5A);
    bus_write(3'd4, 8'h21); bus_read(3'd4, rd); check("R9 mcr", rd, 8'h21);

    // R2 paging
    bus_write(3'd2, 8'h10);
    bus_read(3'd2, rd); check("R2 unpaged read", rd, 0);
    bus_write(3'd3, 8'hBF);
    bus_read(3'd2, rd); check("R2 unpaged write ignored", rd, 0);
    bus_write(3'd2, 8'h10);
    bus_read(3'd2, rd); check("R2 paged readback", rd, 8'h10);
    bus_write(3'd3, 8'h03);
    bus_read(3'd2, rd); check("R2 paged out", rd, 0);

    // R3 load with enhanced on (left on from paging above)
    bus_write(3'd7, 8'h01);
    bus_read(3'd7, rd); check("R5 idx readback", rd, 8'h01);
    bus_write(3'd5, 8'h09); exp_ratio = 8'h09;
    check("R3 ratio load", prescale_value, 8'h09);

    // R6 pass-through with clock select clear
    check_pattern("R6", 0, 12);

    // R7 clock select set restarts the pattern
    bus_write(3'd4, 8'h80);
    check_pattern("R7 ratio 9", 9, 27);

    // R5 other index
    bus_write(3'd7, 8'h02);
    bus_write(3'd5, 8'h33);
    check("R5 other index", prescale_value, exp_ratio);

    // R4 locked window
    set_enh(1'b0);
    bus_write(3'd7, 8'h01);
    bus_write(3'd5, 8'h44);
    check("R4 locked", prescale_value, exp_ratio);
    set_enh(1'b1);

    // R8 below-one ratios
    bus_write(3'd5, 8'h00); exp_ratio = 8'h00;
    check_pattern("R8 ratio 0", 0, 10);
    bus_write(3'd5, 8'h05); exp_ratio = 8'h05;
    check_pattern("R8 ratio 5", 5, 10);
    bus_write(3'd5, 8'h08);
    check_pattern("R7 ratio 8", 8, 10);
    bus_write(3'd5, 8'hFF);
    check_pattern("R7 ratio 255", 255, 300);
    exp_ratio = 8'hFF;

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [7:0] p;
      bit enh, hit;
      p   = 8'($urandom);
      enh = ($urandom % 4) != 0;
      hit = ($urandom % 4) != 0;
      set_enh(enh);
      bus_write(3'd7, hit ? 8'h01 : 8'(($urandom % 255) + 2));
      bus_write(3'd5, p);
      if (enh && hit) begin
        exp_ratio = p;
        check("R3 random load", prescale_value, exp_ratio);
        check_pattern("R7 random", int'(p), 2 * ((p < 8) ? 8 : int'(p)));
      end else begin
        check(enh ? "R5 random" : "R4 random", prescale_value, exp_ratio);
      end
    end

    // R6 clear clock select again
    bus_write(3'd4, 8'h00);
    check_pattern("R6 after", 0, 8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule